// File: doc/BRIEF.md
# Programmable Interval Timer

A three-channel interval timer. Each channel holds a 16-bit initial count and counts the pulses of a shared tick enable (`tick_i`). It drives one output bit whose waveform depends on a 3-bit mode: a terminal-count flag, a retriggerable-style one-shot level, a rate pulse, a square wave, or a single strobe. Counting in a channel advances only while that channel's registered gate is high.

Software reaches the channels through a byte-wide port with four addresses. Addresses 0 to 2 are the channel data registers and address 3 takes a control word. A control word either reprograms one channel or freezes a channel's current value for a stable two-byte read. A read-back form of the control word freezes the count and/or a status byte of several channels at once. The BCD flag is stored and reported but counting is always binary.

Top module: `pit_timer`

## Requirements
- R1: After reset every channel is in mode 3 with access mode 11 and an effective count of 65536, so every output is high and a live read of the count returns 0x00 for both bytes.
- R2: A control word written to address 3 has channel select in bits 7:6 (0 to 2), access mode in bits 5:4 (00 latch, 01 low byte only, 10 high byte only, 11 low then high), mode in bits 3:1 and the BCD flag in bit 0; a non-latch control word stops the channel until a count is loaded, with the output low in mode 0 and high in every other mode.
- R3: Mode 0: after a count N is loaded the output is low and goes high when N ticks have elapsed, then stays high.
- R4: Mode 1: the output is high while fewer than N ticks have elapsed and low from the N-th tick on.
- R5: Mode 2: the output is high for exactly the ticks where the elapsed count is a nonzero multiple of N, repeating without reload (with N = 1 it stays high after the first tick).
- R6: Mode 3: within each period of N ticks the output is high for the first (N+1)>>1 ticks and low for the rest.
- R7: Modes 4 and 5: the output is high only while the elapsed tick count equals N and never again afterwards.
- R8: Mode codes 6 and 7 behave exactly as mode 0.
- R9: A loaded count of 0 acts as 65536.
- R10: With access mode 11 the count takes effect only on the second (high) data byte; with 01 the high byte becomes 0; with 10 the low byte becomes 0 and reads return the high byte of the count.
- R11: A latch control word (access mode 00) copies the channel's current value (count minus elapsed ticks within the period); reads then return that copy low byte first, the copy is held until both bytes are read, and a further latch while one is held is ignored.
- R12: A control word with bits 7:6 = 11 is a read-back: bit 5 low latches counts, bit 4 low latches status, bits 1, 2, 3 select channels 0, 1, 2; the status byte is out in bit 7, gate in bit 6, access mode in 5:4, mode in 3:1, BCD in 0, and is returned by the first read before any latched count.
- R13: A channel counts ticks only while its gate, registered one clock after `gate_i`, is high; gates reset to 1, 1, 0 for channels 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable at the timer input rate |
| gate_i | input | 3 | Per-channel gate |
| wr_en_i | input | 1 | Port write strobe |
| rd_en_i | input | 1 | Port read strobe (ignored when wr_en_i is high) |
| addr_i | input | 2 | 0 to 2 channel data, 3 control word |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed channel |
| out_o | output | 3 | Channel outputs |

## Verification
On every cycle the assertions check that a mode 0 output never drops while the count stands, that strobe and rate pulses last exactly one tick, that a control word leaves the output at the stopped level, that a held latch copy does not move, and that status reads do not disturb the count byte order. The exact tick on which each mode's output changes for counts 1, 2, 3 and 65536, byte ordering across access modes, and the values returned by latch and read-back are shown only by the bench's directed scenarios.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    MODE_TC     = 3'd0,
    MODE_ONCE   = 3'd1,
    MODE_RATE   = 3'd2,
    MODE_SQUARE = 3'd3,
    MODE_SSTRB  = 3'd4,
    MODE_HSTRB  = 3'd5
  } mode_e;

  typedef struct packed {
    logic       out;
    logic       gate;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } status_t;

  function automatic mode_e norm_mode(input logic [2:0] m);
    return (m > 3'd5) ? MODE_TC : mode_e'(m);
  endfunction
endpackage

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter
  import pit_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  input  logic         disarm_i,
  input  mode_e        mode_i,
  input  logic         tick_i,
  output logic         out_o,
  output logic [W-1:0] value_o
);
  localparam int EW = W + 1;
  localparam logic [EW-1:0] FULL = {1'b1, {W{1'b0}}};

  logic [EW-1:0] period_q, elapsed_q, phase_q, half;
  logic          armed_q;

  assign half = EW'(({1'b0, period_q} + 1'b1) >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q  <= FULL;
      elapsed_q <= '0;
      phase_q   <= '0;
      armed_q   <= 1'b1;
    end else if (load_i) begin
      period_q  <= (count_i == '0) ? FULL : {1'b0, count_i};
      elapsed_q <= '0;
      phase_q   <= '0;
      armed_q   <= 1'b1;
    end else if (disarm_i) begin
      armed_q   <= 1'b0;
    end else if (armed_q && tick_i) begin
      // saturate one past the count: enough for every one-shot mode
      if (elapsed_q != period_q + EW'(1)) elapsed_q <= elapsed_q + EW'(1);
      phase_q <= (phase_q == period_q - EW'(1)) ? '0 : phase_q + EW'(1);
    end
  end

  always_comb begin
    if (!armed_q) out_o = (mode_i != MODE_TC);
    else begin
      unique case (mode_i)
        MODE_TC:     out_o = (elapsed_q >= period_q);
        MODE_ONCE:   out_o = (elapsed_q <  period_q);
        MODE_RATE:   out_o = (phase_q == '0) && (elapsed_q != '0);
        MODE_SQUARE: out_o = (phase_q <  half);
        default:     out_o = (elapsed_q == period_q);
      endcase
    end
  end

  assign value_o = W'(period_q - phase_q);

  assert_tc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && mode_i == MODE_TC && out_o && !load_i && !disarm_i) |=> out_o);

  assert_strobe_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (mode_i == MODE_SSTRB || mode_i == MODE_HSTRB) && out_o && tick_i
     && !load_i && !disarm_i) |=> !out_o);

  assert_rate_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && mode_i == MODE_RATE && out_o && tick_i && period_q != EW'(1)
     && !load_i && !disarm_i) |=> !out_o);

  assert_stopped_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_i && !load_i) |=> (out_o == (mode_i != MODE_TC)));

  assert_phase_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < period_q);
endmodule

// File: rtl/pit_port.sv
`timescale 1ns/1ps
module pit_port
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  acc_e              cfg_acc_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic              cfg_bcd_i,
  input  logic              cnt_latch_i,
  input  logic              sts_latch_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              data_re_i,
  input  logic [CNT_W-1:0]  value_i,
  input  logic              out_i,
  input  logic              gate_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output mode_e             mode_o
);
  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q, wr_hi_q, rd_hi_q, lat_vld_q, sts_vld_q;
  logic [BYTE_W-1:0] pend_q;
  logic [CNT_W-1:0]  lat_q, rd_word;
  status_t           sts_q;

  assign mode_o = norm_mode(mode_q);

  always_comb begin
    load_o     = 1'b0;
    load_val_o = '0;
    if (data_we_i) begin
      unique case (acc_q)
        ACC_LO:   begin load_o = 1'b1; load_val_o = {8'h00, wdata_i}; end
        ACC_HI:   begin load_o = 1'b1; load_val_o = {wdata_i, 8'h00}; end
        ACC_WORD: begin load_o = wr_hi_q; load_val_o = {wdata_i, pend_q}; end
        default:  ;
      endcase
    end
  end

  assign rd_word = lat_vld_q ? lat_q : value_i;

  always_comb begin
    if (sts_vld_q) rdata_o = sts_q;
    else begin
      unique case (acc_q)
        ACC_HI:   rdata_o = rd_word[15:8];
        ACC_WORD: rdata_o = rd_hi_q ? rd_word[15:8] : rd_word[7:0];
        default:  rdata_o = rd_word[7:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= ACC_WORD;
      mode_q    <= 3'd3;
      bcd_q     <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      pend_q    <= '0;
      lat_q     <= '0;
      lat_vld_q <= 1'b0;
      sts_q     <= '0;
      sts_vld_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        acc_q   <= cfg_acc_i;
        mode_q  <= cfg_mode_i;
        bcd_q   <= cfg_bcd_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (data_we_i && acc_q == ACC_WORD) begin
        if (!wr_hi_q) pend_q <= wdata_i;
        wr_hi_q <= !wr_hi_q;
      end
      if (cnt_latch_i && !lat_vld_q) begin
        lat_q     <= value_i;
        lat_vld_q <= 1'b1;
      end
      if (sts_latch_i && !sts_vld_q) begin
        sts_q     <= '{out: out_i, gate: gate_i, acc: acc_q, mode: mode_q, bcd: bcd_q};
        sts_vld_q <= 1'b1;
      end
      if (data_re_i) begin
        if (sts_vld_q) sts_vld_q <= 1'b0;
        else begin
          if (acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
          if (acc_q != ACC_WORD || rd_hi_q) lat_vld_q <= 1'b0;
        end
      end
    end
  end

  assert_latch_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_vld_q && !(data_re_i && !sts_vld_q)) |=> (lat_vld_q && $stable(lat_q)));

  assert_word_first_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && acc_q == ACC_WORD && !wr_hi_q && !cfg_we_i) |=> wr_hi_q);

  assert_status_first_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_vld_q && data_re_i && !cfg_we_i) |=> (!sts_vld_q && $stable(rd_hi_q)));
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter bit GATE_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              cfg_we_i,
  input  acc_e              cfg_acc_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic              cfg_bcd_i,
  input  logic              cnt_latch_i,
  input  logic              sts_latch_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              data_re_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o
);
  logic             gate_q, load;
  logic [CNT_W-1:0] load_val, value;
  mode_e            mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= GATE_RST;
    else         gate_q <= gate_i;
  end

  pit_port u_port (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_acc_i, .cfg_mode_i, .cfg_bcd_i,
    .cnt_latch_i, .sts_latch_i, .data_we_i, .wdata_i, .data_re_i,
    .value_i(value), .out_i(out_o), .gate_i(gate_q), .rdata_o,
    .load_o(load), .load_val_o(load_val), .mode_o(mode)
  );

  pit_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .count_i(load_val), .disarm_i(cfg_we_i),
    .mode_i(mode), .tick_i(tick_i && gate_q), .out_o, .value_o(value)
  );

  assert_gate_freeze_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_q && !load && !cfg_we_i) |=> $stable(value));
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] gate_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] out_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic              ctrl_wr, rb;
  logic [1:0]        sel;
  acc_e              acc;
  logic [BYTE_W-1:0] ch_rdata [NUM_CH];
  logic [NUM_CH-1:0] cfg_we;

  assign ctrl_wr = wr_en_i && (addr_i == CTRL_ADDR);
  assign sel     = wdata_i[7:6];
  assign rb      = (sel == 2'b11);
  assign acc     = acc_e'(wdata_i[5:4]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic own, sel_rb;
    assign own       = ctrl_wr && !rb && (sel == 2'(i));
    assign sel_rb    = ctrl_wr && rb && wdata_i[1+i];
    assign cfg_we[i] = own && (acc != ACC_LATCH);

    pit_channel #(.GATE_RST(i != 2)) u_ch (
      .clk_i, .rst_ni, .tick_i, .gate_i(gate_i[i]),
      .cfg_we_i(cfg_we[i]), .cfg_acc_i(acc), .cfg_mode_i(wdata_i[3:1]),
      .cfg_bcd_i(wdata_i[0]),
      .cnt_latch_i((own && acc == ACC_LATCH) || (sel_rb && !wdata_i[5])),
      .sts_latch_i(sel_rb && !wdata_i[4]),
      .data_we_i(wr_en_i && addr_i == 2'(i)), .wdata_i,
      .data_re_i(rd_en_i && !wr_en_i && addr_i == 2'(i)),
      .rdata_o(ch_rdata[i]), .out_o(out_o[i])
    );
  end

  assign rdata_o = (addr_i < 2'(NUM_CH)) ? ch_rdata[addr_i] : '1;

  assert_single_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_we));
endmodule

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;
  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic [2:0] gate_i = 3'b011;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [2:0] out_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  pit_timer dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a; #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk_i); tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  function automatic bit exp_out(input int mode, input int n, input int k);
    int p = (n == 0) ? 65536 : n;
    int m = (mode > 5) ? 0 : mode;
    case (m)
      0: return k >= p;
      1: return k < p;
      2: return (k != 0) && (k % p == 0);
      3: return (k % p) < ((p + 1) / 2);
      default: return k == p;
    endcase
  endfunction

  task automatic program0(input int mode, input int n);
    wr(2'd3, 8'h30 | 8'(mode << 1));
    wr(2'd0, 8'(n));
    wr(2'd0, 8'(n >> 8));
  endtask

  task automatic t_reset;
    logic [7:0] b;
    chk("R1 outputs", out_o, 3'b111);
    wr(2'd3, 8'hE2);
    rd(2'd0, b); chk("R1/R12 status ch0", b, 8'hF6);
    rd(2'd1, b); chk("R1 live low", b, 8'h00);
    rd(2'd1, b); chk("R1 live high", b, 8'h00);
  endtask

  task automatic t_modes;
    for (int mode = 0; mode < 8; mode++) begin
      for (int n = 1; n <= 3; n++) begin
        string tag;
        case (mode)
          0: tag = "R3 mode0"; 1: tag = "R4 mode1"; 2: tag = "R5 mode2";
          3: tag = "R6 mode3"; 4, 5: tag = "R7 strobe"; default: tag = "R8 undefined";
        endcase
        program0(mode, n);
        chk(tag, out_o[0], exp_out(mode, n, 0));
        for (int k = 1; k <= 2 * n + 2; k++) begin
          ticks(1);
          chk(tag, out_o[0], exp_out(mode, n, k));
        end
      end
    end
  endtask

  task automatic t_zero;
    program0(0, 0);
    ticks(65535); chk("R9 mode0 65535", out_o[0], 0);
    ticks(1);     chk("R9 mode0 65536", out_o[0], 1);
    program0(3, 0);
    ticks(32767); chk("R9 mode3 32767", out_o[0], 1);
    ticks(1);     chk("R9 mode3 32768", out_o[0], 0);
  endtask

  task automatic t_stop;
    wr(2'd3, 8'h30); chk("R2 stopped mode0", out_o[0], 0);
    ticks(3);        chk("R2 no count while stopped", out_o[0], 0);
    wr(2'd3, 8'h32); chk("R2 stopped mode1", out_o[0], 1);
  endtask

  task automatic t_access;
    logic [7:0] b;
    wr(2'd3, 8'h30); wr(2'd0, 8'h02);
    ticks(5); chk("R10 half written", out_o[0], 0);
    wr(2'd0, 8'h00);
    ticks(1); chk("R10 after high byte 1", out_o[0], 0);
    ticks(1); chk("R10 after high byte 2", out_o[0], 1);
    wr(2'd3, 8'h10); wr(2'd0, 8'h03);
    ticks(2); chk("R10 low only 2", out_o[0], 0);
    ticks(1); chk("R10 low only 3", out_o[0], 1);
    wr(2'd3, 8'h24); wr(2'd0, 8'h01);
    rd(2'd0, b); chk("R10 high only read 256", b, 8'h01);
    ticks(1);
    rd(2'd0, b); chk("R10 high only read 255", b, 8'h00);
  endtask

  task automatic t_latch;
    logic [7:0] b;
    program0(2, 1000);
    ticks(10);
    wr(2'd3, 8'h00);
    ticks(5);
    wr(2'd3, 8'h00);
    rd(2'd0, b); chk("R11 latched low", b, 8'hDE);
    ticks(3);
    rd(2'd0, b); chk("R11 latched high", b, 8'h03);
    rd(2'd0, b); chk("R11 released low", b, 8'hD6);
    rd(2'd0, b); chk("R11 released high", b, 8'h03);
  endtask

  task automatic t_readback;
    logic [7:0] b;
    wr(2'd3, 8'h73); wr(2'd1, 8'h12); wr(2'd1, 8'h00);
    ticks(3);
    wr(2'd3, 8'hC4);
    rd(2'd1, b); chk("R12 status ch1", b, 8'hF3);
    rd(2'd1, b); chk("R12 count low binary", b, 8'h0F);
    rd(2'd1, b); chk("R12 count high", b, 8'h00);
  endtask

  task automatic t_gate;
    wr(2'd3, 8'hB0); wr(2'd2, 8'h02); wr(2'd2, 8'h00);
    ticks(4); chk("R13 gate low holds", out_o[2], 0);
    gate_i[2] = 1'b1;
    @(negedge clk_i);
    ticks(1); chk("R13 gate high 1", out_o[2], 0);
    ticks(1); chk("R13 gate high 2", out_o[2], 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_stop();
    t_modes();
    t_access();
    t_latch();
    t_readback();
    t_gate();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule